// File: doc/BRIEF.md
# Byte-Exchange SPI Master with Register Interface

This block is a small SPI master that a processor drives through four 32-bit word registers on a simple synchronous bus. Software sets the clock divider, polarity and phase in a configuration word. It selects a target by setting one of the per-device select bits in the control word. It then stores a byte into the transmit register, and that store alone starts a full-duplex exchange of eight bits on separate output and input data lines.

While the byte shifts, a ready bit in the control word reads low. When the ready bit reads high again, the byte captured from the input line sits in the receive register. When there is nothing to send, software stores 0x00, and a byte is still clocked in. A flush request bit and a queue enable bit are kept in the configuration word as plain state. The flush bit drops on its own one cycle after it is set. Every transfer moves exactly one byte, over one output line and one input line.

Top module: `spi_legacy_master`

## Requirements
- R1: After reset the control word reads 0x00000002 (ready set, no selects), the configuration and receive words read 0, every active-low select output is high, and `spi_sclk` and `spi_mosi` are low.
- R2: Word offsets are 0x0 control, 0x4 configuration, 0x8 transmit (reads 0) and 0xC receive. The configuration word keeps divider [4:0], byte-length bit 5, phase bit 6, polarity bit 7, flush bit 9 and queue-enable bit 17; all other bits read 0.
- R3: A store to offset 0x8 while ready is high sends bits [7:0] of the stored word on `spi_mosi`, most significant bit first.
- R4: The eight bits sampled from `spi_miso` appear zero-extended in receive word bits [7:0]. Ready returns high on the same clock edge that the receive word is updated, exactly 16 x D clocks after the store edge, where D is the effective divider.
- R5: Control bit 1 reads 0 from the store edge until the transfer completes.
- R6: Each SCLK half period lasts D input clocks, where D is the divider field; a divider of 0 acts as 1.
- R7: While idle, `spi_sclk` equals the polarity bit. With phase 0, data is sampled on the first (leading) edge of each bit and changed on the trailing edge. With phase 1, data is changed on the leading edge and sampled on the trailing edge.
- R8: Each transfer produces exactly 16 SCLK transitions and ends with SCLK at its idle level.
- R9: Control bit 16+n drives `spi_cs_n[n]` low for as long as the bit stays set, and reads back from the control word.
- R10: A store to offset 0x8 while ready is low is ignored. The byte in flight, its timing and its received data are unchanged.
- R11: The flush bit reads 1 for the one cycle after it is written as 1, then reads 0. The flush, queue-enable and byte-length bits have no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, with bus_sel |
| bus_addr | input | 4 | Byte offset of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NUM_CS | Active-low device selects |

## Verification
The hardest case to reach from the ports is a transmit store that lands while a byte is still shifting, because the bus must be driven in the middle of a bit window. The stimulus injects a store with a different byte a few cycles into a transfer, then checks that the byte serialised and the byte received still match the first store, and that the cycle count is unchanged. A slave model in the bench launches and samples bits on the edges that each mode defines. Random dividers, including 0, and all four modes then vary the edge placement.

// File: rtl/spi_lm_pkg.sv
package spi_lm_pkg;

    localparam int BYTE_BITS = 8;
    localparam int EDGE_CNT  = 2 * BYTE_BITS;
    localparam int EDGE_W    = $clog2(EDGE_CNT);
    localparam int DIV_W     = 5;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_CFG  = 2'd1;
    localparam logic [1:0] SEL_TX   = 2'd2;
    localparam logic [1:0] SEL_RX   = 2'd3;

    typedef struct packed {
        logic [DIV_W-1:0] divider;
        logic             one_byte_n;
        logic             phase;
        logic             polarity;
        logic             flush;
        logic             queue_en;
    } cfg_t;

    function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] raw);
        return (raw == '0) ? DIV_W'(1) : raw;
    endfunction

endpackage

// File: rtl/spi_lm_regs.sv
module spi_lm_regs
    import spi_lm_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_i,
    input  logic                 wr_i,
    input  logic [3:0]           addr_i,
    input  logic [31:0]          wdata_i,
    output logic [31:0]          rdata_o,
    input  logic                 ready_i,
    input  logic                 rx_valid_i,
    input  logic [BYTE_BITS-1:0] rx_byte_i,
    output logic                 start_o,
    output logic [BYTE_BITS-1:0] tx_byte_o,
    output cfg_t                 cfg_o,
    output logic [NUM_CS-1:0]    cs_en_o
);

    typedef struct packed {
        cfg_t                 cfg;
        logic [NUM_CS-1:0]    cs_en;
        logic [BYTE_BITS-1:0] rx;
    } regs_t;

    regs_t       st_d, st_q;
    logic        wr_hit;
    logic [1:0]  word_sel;

    assign word_sel = addr_i[3:2];
    assign wr_hit   = sel_i && wr_i;

    always_comb begin
        st_d           = st_q;
        st_d.cfg.flush = 1'b0;
        if (wr_hit && word_sel == SEL_CTRL) begin
            st_d.cs_en = wdata_i[16 +: NUM_CS];
        end
        if (wr_hit && word_sel == SEL_CFG) begin
            st_d.cfg.divider    = wdata_i[DIV_W-1:0];
            st_d.cfg.one_byte_n = wdata_i[5];
            st_d.cfg.phase      = wdata_i[6];
            st_d.cfg.polarity   = wdata_i[7];
            st_d.cfg.flush      = wdata_i[9];
            st_d.cfg.queue_en   = wdata_i[17];
        end
        if (rx_valid_i) begin
            st_d.rx = rx_byte_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        case (word_sel)
            SEL_CTRL: begin
                rdata_o[1]           = ready_i;
                rdata_o[16 +: NUM_CS] = st_q.cs_en;
            end
            SEL_CFG: begin
                rdata_o[DIV_W-1:0] = st_q.cfg.divider;
                rdata_o[5]         = st_q.cfg.one_byte_n;
                rdata_o[6]         = st_q.cfg.phase;
                rdata_o[7]         = st_q.cfg.polarity;
                rdata_o[9]         = st_q.cfg.flush;
                rdata_o[17]        = st_q.cfg.queue_en;
            end
            SEL_RX:  rdata_o[BYTE_BITS-1:0] = st_q.rx;
            default: rdata_o = '0;
        endcase
    end

    assign start_o   = wr_hit && (word_sel == SEL_TX);
    assign tx_byte_o = wdata_i[BYTE_BITS-1:0];
    assign cfg_o     = st_q.cfg;
    assign cs_en_o   = st_q.cs_en;

    AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cfg.flush && !(wr_hit && word_sel == SEL_CFG && wdata_i[9]) |=> !st_q.cfg.flush) // R11
        else $error("flush bit held");

    AST_RX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid_i |=> $stable(st_q.rx)) // R4
        else $error("receive word changed without completion");

endmodule

// File: rtl/spi_lm_shifter.sv
module spi_lm_shifter
    import spi_lm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [BYTE_BITS-1:0] tx_byte_i,
    input  cfg_t                 cfg_i,
    input  logic                 miso_i,
    output logic                 ready_o,
    output logic                 done_o,
    output logic [BYTE_BITS-1:0] rx_byte_o,
    output logic                 sclk_o,
    output logic                 mosi_o
);

    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGE_CNT - 1);

    typedef struct packed {
        logic                 busy;
        logic [DIV_W-1:0]     div;
        logic [EDGE_W-1:0]    edge_n;
        logic                 sclk;
        logic [BYTE_BITS-1:0] tx;
        logic [BYTE_BITS-1:0] rx;
        logic                 cpol;
        logic                 cpha;
        logic [DIV_W-1:0]     period;
    } shift_t;

    shift_t st_d, st_q;
    logic   tick, leading, do_sample, do_launch;

    always_comb begin
        st_d      = st_q;
        done_o    = 1'b0;
        tick      = (st_q.div == st_q.period - DIV_W'(1));
        leading   = ~st_q.edge_n[0];
        do_sample = st_q.cpha ? ~leading : leading;
        do_launch = st_q.cpha ? (leading && st_q.edge_n != '0) : ~leading;
        if (!st_q.busy) begin
            st_d.sclk = cfg_i.polarity;
            if (start_i) begin
                st_d.busy   = 1'b1;
                st_d.div    = '0;
                st_d.edge_n = '0;
                st_d.tx     = tx_byte_i;
                st_d.cpol   = cfg_i.polarity;
                st_d.cpha   = cfg_i.phase;
                st_d.period = eff_div(cfg_i.divider);
            end
        end else if (tick) begin
            st_d.div    = '0;
            st_d.sclk   = ~st_q.sclk;
            st_d.edge_n = st_q.edge_n + EDGE_W'(1);
            if (do_sample) st_d.rx = {st_q.rx[BYTE_BITS-2:0], miso_i};
            if (do_launch) st_d.tx = {st_q.tx[BYTE_BITS-2:0], 1'b0};
            if (st_q.edge_n == LAST_EDGE) begin
                st_d.busy = 1'b0;
                done_o    = 1'b1;
            end
        end else begin
            st_d.div = st_q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready_o   = ~st_q.busy;
    assign rx_byte_o = st_d.rx;
    assign sclk_o    = st_q.busy ? st_q.sclk : cfg_i.polarity;
    assign mosi_o    = st_q.tx[BYTE_BITS-1];

    AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.div < st_q.period)) // R6
        else $error("divider counter out of range");

    AST_END_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> (st_q.sclk == st_q.cpol)) // R8
        else $error("clock not at idle level at end");

    AST_FRESH_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> (st_q.edge_n == '0 && st_q.div == '0)) // R8
        else $error("transfer started mid-count");

    AST_BUSY_STORE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy && start_i && !done_o |=> st_q.busy
            && (st_q.edge_n == $past(st_q.edge_n) || st_q.edge_n == $past(st_q.edge_n) + EDGE_W'(1))) // R10
        else $error("store while busy disturbed transfer");

endmodule

// File: rtl/spi_legacy_master.sv
module spi_legacy_master
    import spi_lm_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_CS-1:0] spi_cs_n
);

    logic                 ready, done, start;
    logic [BYTE_BITS-1:0] rx_byte, tx_byte;
    cfg_t                 cfg;
    logic [NUM_CS-1:0]    cs_en;

    spi_lm_regs #(.NUM_CS(NUM_CS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (bus_sel),
        .wr_i       (bus_wr),
        .addr_i     (bus_addr),
        .wdata_i    (bus_wdata),
        .rdata_o    (bus_rdata),
        .ready_i    (ready),
        .rx_valid_i (done),
        .rx_byte_i  (rx_byte),
        .start_o    (start),
        .tx_byte_o  (tx_byte),
        .cfg_o      (cfg),
        .cs_en_o    (cs_en)
    );

    spi_lm_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .tx_byte_i (tx_byte),
        .cfg_i     (cfg),
        .miso_i    (spi_miso),
        .ready_o   (ready),
        .done_o    (done),
        .rx_byte_o (rx_byte),
        .sclk_o    (spi_sclk),
        .mosi_o    (spi_mosi)
    );

    assign spi_cs_n = ~cs_en;

endmodule

// File: tb/spi_legacy_master_test.sv
module spi_legacy_master_test;

    localparam int NCS = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]      bus_addr = 4'h0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            spi_sclk, spi_mosi;
    logic            spi_miso = 1'b0;
    logic [NCS-1:0]  spi_cs_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    spi_legacy_master #(.NUM_CS(NCS)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n)
    );

    function automatic int exp_cycles(input logic [4:0] div);
        return 16 * ((div == 5'd0) ? 1 : int'(div));
    endfunction

    function automatic logic [31:0] cfg_word(input logic [4:0] div, input logic cpol,
                                             input logic cpha, input logic [31:0] extra);
        return extra | {24'd0, cpol, cpha, 1'b0, div};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 4'h0;
        #1;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = 4'h0;
        #1;
    endtask

    task automatic xfer(input logic [7:0] tx, input logic [7:0] sb, input logic cpol,
                        input logic cpha, input logic [4:0] div, input logic [31:0] extra,
                        input bit intrude);
        logic [7:0]  got;
        logic [31:0] rd;
        logic        prev;
        int          k, ec, cyc;
        bit          junk;
        bus_write(4'h4, cfg_word(div, cpol, cpha, extra));
        chk("R7 idle level", {31'd0, spi_sclk}, {31'd0, cpol});
        k = cpha ? 0 : 1;
        spi_miso = cpha ? 1'b0 : sb[7];
        got = '0; ec = 0; cyc = 0; junk = 0;
        prev = spi_sclk;
        bus_write(4'h8, {24'hABCDE5, tx});
        while (1) begin
            if (junk) begin
                bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 4'h0; junk = 0;
                #1;
            end
            if (spi_sclk !== prev) begin
                if (cpha ? ec[0] : !ec[0]) got = {got[6:0], spi_mosi};
                if ((cpha ? !ec[0] : ec[0]) && k < 8) begin
                    spi_miso = sb[7-k];
                    k++;
                end
                ec++;
                prev = spi_sclk;
            end
            if (bus_rdata[1]) break;
            if (cyc == 2) chk("R5 ready low while shifting", {31'd0, bus_rdata[1]}, 32'd0);
            cyc++;
            if (intrude && cyc == 3) begin
                bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'h8; bus_wdata = {24'd0, ~tx};
                junk = 1;
            end
            if (cyc > 5000) break;
            @(negedge clk);
        end
        chk("R3 serialised byte", {24'd0, got}, {24'd0, tx});
        chk("R4/R6 cycles to ready", cyc, exp_cycles(div));
        chk("R8 edge count", ec, 16);
        chk("R8 clock at idle after", {31'd0, spi_sclk}, {31'd0, cpol});
        bus_read(4'hC, rd);
        chk(intrude ? "R10 receive after ignored store" : "R4 receive word", rd, {24'd0, sb});
    endtask

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        bus_read(4'h0, rd); chk("R1 control", rd, 32'h2);
        bus_read(4'h4, rd); chk("R1 config", rd, 32'h0);
        bus_read(4'hC, rd); chk("R1 receive", rd, 32'h0);
        chk("R1 selects", {28'd0, spi_cs_n}, {28'd0, 4'hF});
        chk("R1 sclk/mosi", {30'd0, spi_sclk, spi_mosi}, 32'd0);

        // R2 field readback, R11 flush self-clear
        bus_write(4'h4, 32'hFFFF_FFFF);
        bus_read(4'h4, rd); chk("R11 flush visible one cycle", rd, 32'h0002_02FF);
        @(negedge clk); #1;
        bus_read(4'h4, rd); chk("R2 config fields / R11 flush cleared", rd, 32'h0002_00FF);
        bus_read(4'h8, rd); chk("R2 transmit reads zero", rd, 32'h0);

        // R9 chip selects
        bus_write(4'h0, 32'h0005_0000);
        chk("R9 selects driven", {28'd0, spi_cs_n}, {28'd0, 4'hA});
        bus_read(4'h0, rd); chk("R9 control readback", rd, 32'h0005_0002);
        bus_write(4'h0, 32'h0008_0002);
        chk("R9 select moved", {28'd0, spi_cs_n}, {28'd0, 4'h7});

        // directed modes
        xfer(8'hA5, 8'h3C, 1'b0, 1'b0, 5'd2, 32'h0, 0);
        xfer(8'h81, 8'hFE, 1'b1, 1'b1, 5'd1, 32'h0, 0);
        xfer(8'h00, 8'h96, 1'b0, 1'b1, 5'd0, 32'h0, 0);   // R6 divider 0, dummy send
        xfer(8'h7E, 8'h01, 1'b1, 1'b0, 5'd31, 32'h0, 0);
        // R10 store during transfer
        xfer(8'hC3, 8'h5A, 1'b0, 1'b0, 5'd3, 32'h0, 1);
        xfer(8'h1F, 8'hE0, 1'b1, 1'b1, 5'd2, 32'h0, 1);
        // R11 flush/queue/byte-length bits do not change the transfer
        xfer(8'h69, 8'hB4, 1'b0, 1'b1, 5'd2, 32'h0002_0220, 0);

        for (int i = 0; i < 24; i++) begin
            logic [7:0] t, s;
            logic [4:0] d;
            t = 8'($urandom);
            s = 8'($urandom);
            d = 5'($urandom % 5);
            xfer(t, s, 1'($urandom), 1'($urandom), d, 32'h0, ($urandom % 4) == 0);
        end

        bus_read(4'h0, rd); chk("R5 ready after all", {31'd0, rd[1]}, 32'd1);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule